// File: doc/BRIEF.md
# Chainable Priority Encoder, 16 Requests

This block turns a set of request lines into the binary index of the highest-numbered line that is asserted. Its building block is an eight-request stage. Each stage has an enable input and two flags: a group flag that says "an enabled request is present", and a pass-down enable that says "enabled, but nothing here". The pass-down enable of one stage feeds the enable of the stage below it, so a stage only reports when every stage above it is empty.

The top level chains two stages into a 16-request encoder with a 4-bit index. The upper stage watches requests 15 to 8 and is always enabled. Its pass-down enable gates the lower stage, which watches requests 7 to 0. Bit 3 of the index is the upper stage's group flag. The three low bits are the OR of the two stages' addresses, which works because a disabled stage drives its address to zero. A parameter chooses between purely combinational outputs and outputs held in a register on the rising clock edge. The registered form clears with a synchronous active-high reset.

Top module: `prienc_cascade16`

## Requirements
- R1: In an enabled stage, the 3-bit address equals the index of the highest-numbered asserted request. Request 7 has the highest priority and request 0 the lowest.
- R2: When a stage's enable is low, its address, group flag and pass-down enable are all 0, whatever the requests are.
- R3: A stage's group flag is 1 exactly when its enable is 1 and at least one of its requests is 1.
- R4: A stage's pass-down enable is 1 exactly when its enable is 1 and all of its requests are 0.
- R5: An enabled stage with no request asserted gives address 000, group flag 0 and pass-down enable 1. The cascade with all 16 requests low gives code 0000, `grp_any` 0 and `chain_out` 1.
- R6: The cascade's `code` is the index (0 to 15) of the highest-numbered asserted request among the 16. Bit 3 of `code` is 1 exactly when any of requests 15 to 8 is asserted.
- R7: `grp_any` is 1 exactly when any of the 16 requests is asserted. `chain_out` is 1 exactly when none is. The two are never equal outside reset.
- R8: With REG_OUT=1, the outputs show the result for the requests sampled at a rising clock edge. The outputs do not change between edges, even when `req` changes.
- R9: With REG_OUT=1, a clock edge with `rst` high sets `code`, `grp_any` and `chain_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| req | input | 16 | Request lines; bit 15 has the highest priority |
| code | output | 4 | Index of the highest asserted request |
| grp_any | output | 1 | At least one request is asserted |
| chain_out | output | 1 | No request asserted; feeds a further stage's enable |

## Verification
Two functions can act in the same cycle. The upper stage reports a hit while, in that same cycle, it suppresses the lower stage's hit through the enable chain. The random 16-bit patterns set bits in both halves together, and the directed cases include 16'h0180 and 16'hFFFF. For each one, the code is compared with a reference loop that scans from bit 15 down, so a lower-stage address leaking into the OR would show up as a wrong index. Reset is also applied while requests are active, and the bench checks that the cleared outputs take precedence over the pending result.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
    localparam int STAGE_LANES = 8;
    localparam int STAGE_IDX_W = $clog2(STAGE_LANES);

    typedef struct packed {
        logic [STAGE_IDX_W:0] code;
        logic                 grp_any;
        logic                 chain_out;
    } casc_res_t;
endpackage

// File: rtl/prienc_stage.sv
module prienc_stage #(
    parameter int LANES = prienc_pkg::STAGE_LANES,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] req,
    input  logic             en_in,
    output logic [IDX_W-1:0] addr,
    output logic             grp,
    output logic             en_out
);
    logic [IDX_W-1:0] idx;
    logic             any;

    always_comb begin
        idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any    = |req;
        addr   = en_in ? idx : '0;
        grp    = en_in & any;
        en_out = en_in & ~any;
    end
endmodule

// File: rtl/prienc_merge.sv
module prienc_merge #(
    parameter int LANES = prienc_pkg::STAGE_LANES,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [IDX_W-1:0] hi_addr,
    input  logic             hi_grp,
    input  logic [IDX_W-1:0] lo_addr,
    input  logic             lo_grp,
    input  logic             lo_en_out,
    output logic [IDX_W:0]   code,
    output logic             grp_any,
    output logic             chain_out
);
    always_comb begin
        code      = {hi_grp, hi_addr | lo_addr};
        grp_any   = hi_grp | lo_grp;
        chain_out = lo_en_out;
    end
endmodule

// File: rtl/prienc_cascade16.sv
module prienc_cascade16 #(
    parameter int LANES   = prienc_pkg::STAGE_LANES,
    parameter bit REG_OUT = 1'b1,
    localparam int IN_W   = 2 * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   req,
    output logic [IDX_W:0]    code,
    output logic              grp_any,
    output logic              chain_out
);
    import prienc_pkg::*;

    logic [IDX_W-1:0] hi_addr, lo_addr;
    logic             hi_grp, hi_en_out, lo_grp, lo_en_out;
    logic [IDX_W:0]   m_code;
    logic             m_grp, m_chain;
    casc_res_t        res_d, res;

    prienc_stage #(.LANES(LANES)) u_hi (
        .req(req[IN_W-1:LANES]), .en_in(1'b1),
        .addr(hi_addr), .grp(hi_grp), .en_out(hi_en_out)
    );

    prienc_stage #(.LANES(LANES)) u_lo (
        .req(req[LANES-1:0]), .en_in(hi_en_out),
        .addr(lo_addr), .grp(lo_grp), .en_out(lo_en_out)
    );

    prienc_merge #(.LANES(LANES)) u_merge (
        .hi_addr(hi_addr), .hi_grp(hi_grp),
        .lo_addr(lo_addr), .lo_grp(lo_grp), .lo_en_out(lo_en_out),
        .code(m_code), .grp_any(m_grp), .chain_out(m_chain)
    );

    always_comb begin
        res_d.code      = m_code;
        res_d.grp_any   = m_grp;
        res_d.chain_out = m_chain;
    end

    generate
        if (REG_OUT) begin : g_reg
            casc_res_t res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_d;
            end
            assign res = res_q;
        end else begin : g_comb
            assign res = res_d;
        end
    endgenerate

    assign code      = res.code;
    assign grp_any   = res.grp_any;
    assign chain_out = res.chain_out;
endmodule

// File: rtl/prienc_cascade16_chk.sv
module prienc_cascade16_chk #(
    parameter int LANES   = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int IN_W   = 2 * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input logic            clk,
    input logic            rst,
    input logic [IN_W-1:0] req,
    input logic [IDX_W:0]  code,
    input logic            grp_any,
    input logic            chain_out
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_reg_chk
            p_reset_r9: assert property (@(posedge clk) rst |=> (code == '0 && !grp_any && !chain_out));
            p_excl_r7: assert property (@(posedge clk) disable iff (rst) past_ok |-> (grp_any != chain_out));
            p_grp_r7: assert property (@(posedge clk) disable iff (rst) past_ok |-> (grp_any == ($past(req) != '0)));
            p_top_bit_r6: assert property (@(posedge clk) disable iff (rst) past_ok |-> (code[IDX_W] == ($past(req[IN_W-1:LANES]) != '0)));
            p_empty_r5: assert property (@(posedge clk) disable iff (rst) (past_ok && $past(req) == '0) |-> (code == '0 && chain_out));
        end else begin : g_comb_chk
            p_excl_r7: assert property (@(posedge clk) disable iff (rst) grp_any != chain_out);
            p_grp_r7: assert property (@(posedge clk) disable iff (rst) grp_any == (req != '0));
            p_top_bit_r6: assert property (@(posedge clk) disable iff (rst) code[IDX_W] == (req[IN_W-1:LANES] != '0));
            p_empty_r5: assert property (@(posedge clk) disable iff (rst) (req == '0) |-> (code == '0 && chain_out));
        end
    endgenerate
endmodule

bind prienc_cascade16 prienc_cascade16_chk #(.LANES(LANES), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .req(req), .code(code),
    .grp_any(grp_any), .chain_out(chain_out)
);

// File: tb/prienc_cascade16_test.sv
module prienc_cascade16_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req = '0;
    logic [3:0]  code;
    logic        grp_any, chain_out;
    logic [7:0]  s_req = '0;
    logic        s_en = 1'b0;
    logic [2:0]  s_addr;
    logic        s_grp, s_eout;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    prienc_cascade16 #(.LANES(8), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .req(req),
        .code(code), .grp_any(grp_any), .chain_out(chain_out)
    );

    prienc_stage #(.LANES(8)) stage_uut (
        .req(s_req), .en_in(s_en), .addr(s_addr), .grp(s_grp), .en_out(s_eout)
    );

    function automatic logic [5:0] ref16(input logic [15:0] r);
        for (int i = 15; i >= 0; i--)
            if (r[i]) return {4'(i), 1'b1, 1'b0};
        return {4'd0, 1'b0, 1'b1};
    endfunction

    function automatic logic [4:0] ref8(input logic [7:0] r, input logic en);
        if (!en) return 5'd0;
        for (int i = 7; i >= 0; i--)
            if (r[i]) return {3'(i), 1'b1, 1'b0};
        return {3'd0, 1'b0, 1'b1};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic casc_apply(input logic [15:0] r, input string tag);
        logic [5:0] e;
        @(negedge clk) req = r;
        @(posedge clk) #1;
        e = ref16(r);
        chk(tag, {10'd0, code, grp_any, chain_out}, {10'd0, e});
    endtask

    initial begin
        logic [4:0] e8;
        logic [5:0] eprev;
        void'($urandom(32'd5731));
        repeat (3) @(posedge clk);
        #1 chk("R9 reset state", {13'd0, code == 4'd0, grp_any, chain_out}, {13'd0, 1'b1, 1'b0, 1'b0});
        @(negedge clk) rst = 1'b0;

        for (int en = 0; en < 2; en++) begin
            for (int p = 0; p < 256; p++) begin
                s_en = en[0]; s_req = 8'(p);
                #1 e8 = ref8(s_req, s_en);
                if (!s_en)
                    chk("R2 disabled stage", {11'd0, s_addr, s_grp, s_eout}, 16'd0);
                else begin
                    chk("R1 stage address", {13'd0, s_addr}, {13'd0, e8[4:2]});
                    chk("R3 group flag", {15'd0, s_grp}, {15'd0, e8[1]});
                    chk("R4 pass-down enable", {15'd0, s_eout}, {15'd0, e8[0]});
                    if (p == 0) chk("R5 empty stage", {11'd0, s_addr, s_grp, s_eout}, 16'b001);
                end
            end
        end

        casc_apply(16'h0000, "R5 cascade empty");
        casc_apply(16'h8000, "R6 top request");
        casc_apply(16'h0001, "R6 bottom request");
        casc_apply(16'h0100, "R6 lowest upper");
        casc_apply(16'h0180, "R6 both halves");
        casc_apply(16'hFFFF, "R6 all set");
        casc_apply(16'h00FF, "R7 lower only");
        for (int k = 0; k < 400; k++) begin
            logic [15:0] r;
            r = 16'($urandom);
            if (k % 4 == 1) r = r & 16'h00FF;
            if (k % 8 == 3) r = 16'h1 << (k % 16);
            casc_apply(r, "R6 random");
        end

        casc_apply(16'h0420, "R8 setup");
        eprev = ref16(16'h0420);
        @(negedge clk) req = 16'h4000;
        #1 chk("R8 hold between edges", {10'd0, code, grp_any, chain_out}, {10'd0, eprev});
        @(posedge clk) #1;
        chk("R8 update on edge", {10'd0, code, grp_any, chain_out}, {10'd0, ref16(16'h4000)});

        @(negedge clk) begin rst = 1'b1; req = 16'hA5A5; end
        @(posedge clk) #1;
        chk("R9 reset with requests", {10'd0, code, grp_any, chain_out}, 16'd0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk) #1;
        chk("R6 after reset", {10'd0, code, grp_any, chain_out}, {10'd0, ref16(16'hA5A5)});

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule